// File: doc/BRIEF.md
# Reload Timer with Fractional-Period Dithering

This block is an 8-bit down-counting timer. The count clock comes from a power-of-two prescaler on the system clock. Each time the counter passes zero it reloads from a software-set value and emits a one-cycle underflow pulse. It can run continuously or stop after a single period.

A dithering field lets the average period be tuned in sixteenths of a count clock. Out of every sixteen consecutive periods, the programmed number are lengthened by one extra count clock. The lengthened periods are chosen by a bit-reversed period index, so they are spread evenly through the group of sixteen rather than bunched together.

Software reaches the timer through a 16-bit register port with five word addresses. An underflow sets a sticky flag. The interrupt request is that flag gated by an enable bit.

Top module: `fine_reload_timer`

## Requirements
- R1: After reset, the divider, reload, control and interrupt registers read 0x0000 and the counter reads 0x00FF. Both underflowPulse and irq are low.
- R2: The register map uses these addresses and fields; writes to the counter address have no effect; every unlisted bit, and any address from 5 to 7, reads 0.
  - Address 0, divider: bits 3:0.
  - Address 1, reload: bits 7:0.
  - Address 2, counter: read-only, bits 7:0.
  - Address 3, control: run in bit 0, restart in bit 1, one-shot in bit 4, dither count in bits 11:8.
  - Address 4, interrupt: flag in bit 0, enable in bit 8.
- R3: Divider codes n from 0 to 14 give one count tick every 2^n clocks while running. Code 15 gives no ticks, so the counter never moves.
- R4: While run is 1, the counter decrements by one on each tick. While run is 0, it holds its value.
- R5: A tick that finds the counter at 0 reloads it and raises underflowPulse for one cycle. With the dither count at 0, underflows repeat every 2^n*(reload+1) clocks.
- R6: The underflows after a restart are numbered j = 0, 1, 2, ... Period j is lengthened by one tick exactly when bit-reverse4(j mod 16) is less than the dither count.
- R7: Writing control with bit 1 set loads the counter from reload, clears the period index and restarts the prescaler. With bit 1 clear, the write leaves the counter alone. Bit 1 always reads 0.
- R8: In one-shot mode (bit 4 = 1), the first underflow clears run. The counter is then left holding the reload value.
- R9: The flag sets on every underflow. Writing 1 to bit 0 of the interrupt register clears it, and writing 0 leaves it unchanged. A set in the same cycle wins over the clear.
- R10: irq is high exactly when both the flag and the enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, combinational from regAddr |
| underflowPulse | output | 1 | One-cycle pulse per underflow |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest behaviour to reach from the ports is the dither pattern. The choice of lengthened periods depends on an internal period index that software can neither read nor set, apart from clearing it. The bench clears the index with a restart write and then times sixteen consecutive underflow intervals. It does this for every dither count, several reload values and several divider codes, and compares each interval with 2^n*(reload+1+stretch) computed from the bit-reversed index. The top divider code is reached with a single long period.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DIV    = 3'd0,
    ADDR_RELOAD = 3'd1,
    ADDR_COUNT  = 3'd2,
    ADDR_CTRL   = 3'd3,
    ADDR_INT    = 3'd4
  } regAddr_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/rtf_counter.sv
module rtf_counter
  import rtf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic             countZero
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '1;
    else if (strobe.load) count <= reloadVal;
    else if (strobe.dec)  count <= count - 1'b1;
  end

  assign countZero = (count == '0);

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load) |=> count == CNT_W'($past(count) - 1'b1));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> count == $past(reloadVal));

  // R5
  no_dec_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dec && countZero));

endmodule

// File: rtl/rtf_ctrl.sv
module rtf_ctrl
  import rtf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 4,
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [CNT_W-1:0]  count,
  input  logic              countZero,
  output cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              underflowPulse,
  output logic              irq
);

  localparam int MAX_SHIFT = (1 << DIV_W) - 2;
  localparam int PRE_W     = MAX_SHIFT;

  logic [DIV_W-1:0]  divSel;
  logic [FINE_W-1:0] fineSel;
  logic              run, oneShot, intFlag, intEn;
  logic [PRE_W-1:0]  presc, prescMask;
  logic              divValid, tick;
  logic [FINE_W-1:0] periodIdx, revIdx;
  logic              holdDone, stretch, needHold, ufNow, holdSet;
  logic              wrDiv, wrReload, wrCtrl, wrInt, restartWr;
  logic              ufQ;
  logic [3:0]        unusedBits;

  assign unusedBits = regWrData[15:12];

  assign wrDiv     = regWrEn && (regAddr == ADDR_DIV);
  assign wrReload  = regWrEn && (regAddr == ADDR_RELOAD);
  assign wrCtrl    = regWrEn && (regAddr == ADDR_CTRL);
  assign wrInt     = regWrEn && (regAddr == ADDR_INT);
  assign restartWr = wrCtrl && regWrData[1];

  // prescaler
  assign divValid  = divSel <= DIV_W'(MAX_SHIFT);
  assign prescMask = ({{(PRE_W-1){1'b0}}, 1'b1} << divSel) - 1'b1;
  assign tick      = run && divValid && ((presc & prescMask) == prescMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 presc <= '0;
    else if (!run || restartWr) presc <= '0;
    else                       presc <= presc + 1'b1;
  end

  // dither selection: bit-reversed period index against the dither count
  for (genvar i = 0; i < FINE_W; i++) begin : g_rev
    assign revIdx[i] = periodIdx[FINE_W-1-i];
  end
  assign stretch  = revIdx < fineSel;
  assign needHold = stretch && !holdDone;

  assign ufNow   = tick && !restartWr && countZero && !needHold;
  assign holdSet = tick && !restartWr && countZero && needHold;

  assign strobe.load = restartWr || ufNow;
  assign strobe.dec  = tick && !restartWr && !countZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodIdx <= '0;
      holdDone  <= 1'b0;
    end else if (restartWr) begin
      periodIdx <= '0;
      holdDone  <= 1'b0;
    end else if (ufNow) begin
      periodIdx <= periodIdx + 1'b1;
      holdDone  <= 1'b0;
    end else if (holdSet) begin
      holdDone  <= 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSel    <= '0;
      reloadVal <= '0;
      fineSel   <= '0;
      oneShot   <= 1'b0;
      run       <= 1'b0;
      intEn     <= 1'b0;
      intFlag   <= 1'b0;
      ufQ       <= 1'b0;
    end else begin
      ufQ <= ufNow;
      if (wrDiv)    divSel    <= regWrData[DIV_W-1:0];
      if (wrReload) reloadVal <= regWrData[CNT_W-1:0];
      if (wrCtrl) begin
        run     <= regWrData[0];
        oneShot <= regWrData[4];
        fineSel <= regWrData[8 +: FINE_W];
      end else if (ufNow && oneShot) begin
        run <= 1'b0;
      end
      if (wrInt) intEn <= regWrData[8];
      if (ufNow)                      intFlag <= 1'b1;
      else if (wrInt && regWrData[0]) intFlag <= 1'b0;
    end
  end

  assign underflowPulse = ufQ;
  assign irq            = intFlag && intEn;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_DIV:    regRdData[DIV_W-1:0] = divSel;
      ADDR_RELOAD: regRdData[CNT_W-1:0] = reloadVal;
      ADDR_COUNT:  regRdData[CNT_W-1:0] = count;
      ADDR_CTRL: begin
        regRdData[0]          = run;
        regRdData[4]          = oneShot;
        regRdData[8 +: FINE_W] = fineSel;
      end
      ADDR_INT: begin
        regRdData[0] = intFlag;
        regRdData[8] = intEn;
      end
      default: regRdData = '0;
    endcase
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ufNow |=> intFlag);

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ufNow && oneShot && !wrCtrl) |=> !run);

  // R5
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !underflowPulse);

  // R6
  hold_then_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdSet |=> countZero);

endmodule

// File: rtl/fine_reload_timer.sv
module fine_reload_timer
  import rtf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 4,
  parameter int FINE_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        underflowPulse,
  output logic        irq
);

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] reloadVal, count;
  logic             countZero;

  rtf_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W), .FINE_W(FINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .count(count),
    .countZero(countZero), .strobe(strobe), .reloadVal(reloadVal),
    .underflowPulse(underflowPulse), .irq(irq)
  );

  rtf_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .count(count), .countZero(countZero)
  );

endmodule

// File: tb/fine_reload_timer_test.sv
`timescale 1ns/100ps
module fine_reload_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        underflowPulse, irq;
  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  fine_reload_timer uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .underflowPulse(underflowPulse), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic int stretchOf(input int j, input int f);
    logic [3:0] idx, rev;
    idx = 4'(j % 16);
    for (int b = 0; b < 4; b++) rev[b] = idx[3-b];
    return (int'(rev) < f) ? 1 : 0;
  endfunction

  // wait for the next pulse, counting negedge samples
  task automatic waitPulse(output int c);
    c = 1;
    @(negedge clk);
    while (!underflowPulse && c < 40000) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int dv, input int rl, input int f, input int nper);
    int c, expT;
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'(dv));
    wr(3'd1, 16'(rl));
    wr(3'd3, 16'((f << 8) | 2));
    wr(3'd3, 16'((f << 8) | 1));
    waitPulse(c);
    c = c - 1;  // first sample after the run edge is index 0
    expT = (1 << dv) * (rl + 1 + stretchOf(0, f));
    check($sformatf("R6 first period div=%0d rl=%0d f=%0d", dv, rl, f), c, expT);
    for (int j = 1; j < nper; j++) begin
      waitPulse(c);
      expT = (1 << dv) * (rl + 1 + stretchOf(j, f));
      check($sformatf("R5/R6 period %0d div=%0d rl=%0d f=%0d", j, dv, rl, f), c, expT);
    end
    wr(3'd3, 16'h0000);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int c;
    bit seen;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(3'd0, d); check("R1 divider", d, 16'h0000);
    rd(3'd1, d); check("R1 reload", d, 16'h0000);
    rd(3'd2, d); check("R1 counter", d, 16'h00FF);
    rd(3'd3, d); check("R1 control", d, 16'h0000);
    rd(3'd4, d); check("R1 interrupt", d, 16'h0000);
    check("R1 outputs", {underflowPulse, irq}, 0);

    // R2 map and reserved bits
    wr(3'd0, 16'hFFFF); rd(3'd0, d); check("R2 divider bits", d, 16'h000F);
    wr(3'd1, 16'hFFFF); rd(3'd1, d); check("R2 reload bits", d, 16'h00FF);
    wr(3'd4, 16'hFFFE); rd(3'd4, d); check("R2 interrupt bits", d, 16'h0100);
    wr(3'd3, 16'hFFFE); rd(3'd3, d); check("R2 control bits", d, 16'h0F10);
    rd(3'd2, d); check("R2 counter loaded", d, 16'h00FF);
    wr(3'd2, 16'h0000); rd(3'd2, d); check("R2 counter read-only", d, 16'h00FF);
    rd(3'd5, d); check("R2 unused address", d, 16'h0000);

    // R3 reserved divider code: no ticks
    wr(3'd3, 16'h0001);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (underflowPulse) seen = 1;
    end
    wr(3'd3, 16'h0000);
    rd(3'd2, d); check("R3 code 15 counter frozen", d, 16'h00FF);
    check("R3 code 15 no pulse", seen, 0);

    // R7 restart write
    wr(3'd1, 16'h0005); wr(3'd3, 16'h0002);
    rd(3'd2, d); check("R7 restart loads", d, 16'h0005);
    wr(3'd1, 16'h0009); wr(3'd3, 16'h0000);
    rd(3'd2, d); check("R7 bit1 clear no effect", d, 16'h0005);
    rd(3'd3, d); check("R7 restart reads 0", d, 16'h0000);

    // R4 decrement and hold
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0001); wr(3'd3, 16'h0000);
    rd(3'd2, d); check("R4 one decrement", d, 16'h0004);
    repeat (10) @(negedge clk);
    rd(3'd2, d); check("R4 hold when stopped", d, 16'h0004);
    wr(3'd0, 16'h0002); wr(3'd3, 16'h0002);
    wr(3'd3, 16'h0001);
    repeat (7) @(posedge clk);
    wr(3'd3, 16'h0000);
    rd(3'd2, d); check("R4/R3 div 4 two decrements", d, 16'h0007);

    // R5/R6 sweep over divider, reload and every dither count
    for (int dv = 0; dv < 3; dv++)
      for (int ri = 0; ri < 3; ri++)
        for (int f = 0; f < 16; f++)
          measure(dv, (ri == 0) ? 0 : (ri == 1) ? 2 : 5, f, 17);

    // R3 largest divider code
    measure(14, 0, 0, 1);

    // R8 one-shot and R9/R10 flag and irq
    wr(3'd4, 16'h0001); rd(3'd4, d); check("R9 flag cleared by 1", d, 16'h0000);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0002); wr(3'd3, 16'h0012);
    wr(3'd3, 16'h0011);
    waitPulse(c);
    check("R8 one-shot period", c - 1, 3);
    rd(3'd3, d); check("R8 run cleared", d, 16'h0010);
    rd(3'd2, d); check("R8 counter holds reload", d, 16'h0002);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (underflowPulse) seen = 1;
    end
    check("R8 no second pulse", seen, 0);
    rd(3'd4, d); check("R9 flag set", d, 16'h0001);
    check("R10 irq masked", irq, 0);
    wr(3'd4, 16'h0100); rd(3'd4, d); check("R9 write 0 keeps flag", d, 16'h0101);
    check("R10 irq asserted", irq, 1);
    wr(3'd4, 16'h0101); rd(3'd4, d); check("R9 clear flag", d, 16'h0100);
    check("R10 irq released", irq, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule